// File: doc/BRIEF.md
# Branch String Staging Register

This block holds the branch string of one packet while that packet is processed. When the key lookup hits, the stored string is copied into the register in a single cycle. The copy can happen before the first branch of the packet. After that, each conditional branch takes its predicted direction from the next bit in the register, and the string table is not read again. When the lookup misses, the register starts empty. It records the resolved direction of each branch instead.

A recorded string has to go back to the table. The register raises a write-back request in one of two cases: as soon as all M positions are filled, or when the packet ends with a partly filled string. The request carries the string and the table index that was latched at load. It stays up until the table acknowledges it. While a request is pending, a new load is held off. Once all M bits have been used, in either mode, an exhausted flag tells the surrounding logic to use the fallback predictor.

Top module: `bstr_stage`

## Requirements
- R1: After reset, pred_bit, pred_exh and wb_req are 0 and ld_rdy is 1.
- R2: A load accepted with ld_hit=1 makes pred_bit equal to bit 0 of ld_data in the cycle after the load.
- R3: In hit mode, after k accepted consumes (k < M), pred_bit equals bit k of the loaded string. Bit 0 is used first.
- R4: pred_exh rises once M branches have been consumed in either mode. While it is high, pred_bit is 0 and further consumes change nothing.
- R5: A load with ld_hit=0 clears the register and ignores ld_data. The k-th resolved outcome (br_taken, 1 = taken) is stored at bit k-1. pred_bit stays 0 while recording.
- R6: The cycle after the M-th outcome is recorded, wb_req rises with all M recorded bits on wb_data and the load's index on wb_idx. A later pkt_end for that packet raises no second request.
- R7: A pkt_end after k recorded outcomes (0 < k < M) raises wb_req in the next cycle. Bits k..M-1 of wb_data are 0.
- R8: A pkt_end raises no request if no outcome was recorded, and it never raises one in hit mode.
- R9: While wb_req is high and wb_ack is low, wb_req, wb_data and wb_idx hold. wb_req falls the cycle after wb_ack.
- R10: ld_rdy is 0 while a request is pending. A load offered then is ignored and leaves pred_bit and pred_exh unchanged.
- R11: A pkt_end (with no load in the same cycle) returns the block to idle. In the next cycle pred_bit and pred_exh are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_vld | input | 1 | Load strobe; taken when ld_rdy is 1 |
| ld_hit | input | 1 | 1: lookup hit, replay ld_data; 0: record outcomes |
| ld_data | input | M | Stored branch string from the table |
| ld_idx | input | IW | Table entry index for this packet |
| ld_rdy | output | 1 | Load can be accepted (no request pending) |
| br_vld | input | 1 | One conditional branch consumed |
| br_taken | input | 1 | Resolved direction of that branch |
| pkt_end | input | 1 | Current packet is finished |
| pred_bit | output | 1 | Predicted direction for the next branch |
| pred_exh | output | 1 | All M bits used; use the fallback predictor |
| wb_req | output | 1 | Write-back request to the table |
| wb_data | output | M | String to write back |
| wb_idx | output | IW | Table entry to write |
| wb_ack | input | 1 | Table has taken the write-back |

## Verification
Every result is registered once, so the effect of a load, consume or packet end shows on the outputs in the cycle after the edge that accepted it. ld_rdy is the only exception: it follows the pending request directly. The driver sets inputs on the falling edge and queues the expected outputs for the next rising edge. The monitor compares just after that edge. The write-back data and index are compared only in cycles where a request is expected. Hold and stall behaviour is checked over several cycles with the acknowledge held low.

// File: rtl/bstr_pkg.sv
package bstr_pkg;
  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_PLAY = 2'd1,
    MD_REC  = 2'd2
  } mode_t;
endpackage

// File: rtl/bstr_ctrl.sv
module bstr_ctrl
  import bstr_pkg::*;
#(
  parameter int M  = 16,
  parameter int CW = $clog2(M + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_go,
  input  logic          ld_hit,
  input  logic          br_vld,
  input  logic          pkt_end,
  output mode_t         mode,
  output logic [CW-1:0] cnt,
  output logic          br_play,
  output logic          br_rec,
  output logic          wb_fire,
  output logic          exh
);
  localparam logic [CW-1:0] FULL = CW'(M);

  logic          br_go;
  logic [CW-1:0] cnt_nx;

  // a consume counts only in an active packet that still has room
  assign br_go   = br_vld && (mode != MD_IDLE) && (cnt != FULL) && !ld_go;
  assign br_play = br_go && (mode == MD_PLAY);
  assign br_rec  = br_go && (mode == MD_REC);
  assign cnt_nx  = cnt + CW'(br_go);

  // one write per recorded packet: when it fills, or at its end if partly filled
  assign wb_fire = !ld_go && (mode == MD_REC) && (cnt != FULL) &&
                   (cnt_nx != '0) && ((cnt_nx == FULL) || pkt_end);

  assign exh = (mode != MD_IDLE) && (cnt == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MD_IDLE;
      cnt  <= '0;
    end else if (ld_go) begin
      mode <= ld_hit ? MD_PLAY : MD_REC;
      cnt  <= '0;
    end else if (pkt_end) begin
      mode <= MD_IDLE;
      cnt  <= '0;
    end else begin
      cnt <= cnt_nx;
    end
  end
endmodule

// File: rtl/bstr_path.sv
module bstr_path #(
  parameter int M  = 16,
  parameter int IW = 4,
  parameter int CW = $clog2(M + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_go,
  input  logic          ld_hit,
  input  logic [M-1:0]  ld_data,
  input  logic [IW-1:0] ld_idx,
  input  logic          br_play,
  input  logic          br_rec,
  input  logic          br_taken,
  input  logic [CW-1:0] cnt,
  output logic [M-1:0]  str_q,
  output logic [M-1:0]  str_nx,
  output logic [IW-1:0] idx_q
);
  localparam int PW = $clog2(M);

  always_comb begin
    str_nx = str_q;
    if (br_play) begin
      str_nx = {1'b0, str_q[M-1:1]};
    end else if (br_rec) begin
      str_nx[cnt[PW-1:0]] = br_taken;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      str_q <= '0;
      idx_q <= '0;
    end else if (ld_go) begin
      str_q <= ld_hit ? ld_data : '0;
      idx_q <= ld_idx;
    end else begin
      str_q <= str_nx;
    end
  end
endmodule

// File: rtl/bstr_wb.sv
module bstr_wb #(
  parameter int M  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wb_fire,
  input  logic [M-1:0]  str_nx,
  input  logic [IW-1:0] idx_q,
  input  logic          wb_ack,
  output logic          wb_req,
  output logic [M-1:0]  wb_data,
  output logic [IW-1:0] wb_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_req  <= 1'b0;
      wb_data <= '0;
      wb_idx  <= '0;
    end else if (wb_fire) begin
      wb_req  <= 1'b1;
      wb_data <= str_nx;
      wb_idx  <= idx_q;
    end else if (wb_req && wb_ack) begin
      wb_req <= 1'b0;
    end
  end
endmodule

// File: rtl/bstr_stage.sv
module bstr_stage
  import bstr_pkg::*;
#(
  parameter int M  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_vld,
  input  logic          ld_hit,
  input  logic [M-1:0]  ld_data,
  input  logic [IW-1:0] ld_idx,
  output logic          ld_rdy,
  input  logic          br_vld,
  input  logic          br_taken,
  input  logic          pkt_end,
  output logic          pred_bit,
  output logic          pred_exh,
  output logic          wb_req,
  output logic [M-1:0]  wb_data,
  output logic [IW-1:0] wb_idx,
  input  logic          wb_ack
);
  localparam int CW = $clog2(M + 1);

  mode_t         mode;
  logic [CW-1:0] cnt;
  logic          ld_go, br_play, br_rec, wb_fire, exh;
  logic [M-1:0]  str_q, str_nx;
  logic [IW-1:0] idx_q;

  assign ld_rdy = !wb_req;
  assign ld_go  = ld_vld && !wb_req;

  bstr_ctrl #(.M(M), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .ld_go(ld_go), .ld_hit(ld_hit), .br_vld(br_vld),
    .pkt_end(pkt_end), .mode(mode), .cnt(cnt), .br_play(br_play),
    .br_rec(br_rec), .wb_fire(wb_fire), .exh(exh)
  );

  bstr_path #(.M(M), .IW(IW), .CW(CW)) u_path (
    .clk(clk), .rst(rst), .ld_go(ld_go), .ld_hit(ld_hit), .ld_data(ld_data),
    .ld_idx(ld_idx), .br_play(br_play), .br_rec(br_rec), .br_taken(br_taken),
    .cnt(cnt), .str_q(str_q), .str_nx(str_nx), .idx_q(idx_q)
  );

  bstr_wb #(.M(M), .IW(IW)) u_wb (
    .clk(clk), .rst(rst), .wb_fire(wb_fire), .str_nx(str_nx), .idx_q(idx_q),
    .wb_ack(wb_ack), .wb_req(wb_req), .wb_data(wb_data), .wb_idx(wb_idx)
  );

  // predictions come only from a replayed string
  assign pred_bit = (mode == MD_PLAY) && str_q[0];
  assign pred_exh = exh;
endmodule

// File: rtl/bstr_stage_chk.sv
module bstr_stage_chk #(
  parameter int M  = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ld_vld,
  input logic          ld_rdy,
  input logic          br_vld,
  input logic          pkt_end,
  input logic          pred_bit,
  input logic          pred_exh,
  input logic          wb_req,
  input logic [M-1:0]  wb_data,
  input logic [IW-1:0] wb_idx,
  input logic          wb_ack
);
  // R9: pending request holds its payload
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    wb_req && !wb_ack |=> wb_req && $stable(wb_data) && $stable(wb_idx));

  // R9: acknowledged request drops
  a_r9_drop: assert property (@(posedge clk) disable iff (rst)
    wb_req && wb_ack |=> !wb_req);

  // R4: no prediction while exhausted
  a_r4_exh_quiet: assert property (@(posedge clk) disable iff (rst)
    pred_exh |-> !pred_bit);

  // R4: exhausted stays until packet end or a new load
  a_r4_exh_hold: assert property (@(posedge clk) disable iff (rst)
    pred_exh && !pkt_end && !ld_vld |=> pred_exh);

  // R10: a stalled load changes no prediction state
  a_r10_stall: assert property (@(posedge clk) disable iff (rst)
    ld_vld && !ld_rdy && !br_vld && !pkt_end |=> $stable(pred_bit) && $stable(pred_exh));

  // R11: packet end returns to idle
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    pkt_end && !(ld_vld && ld_rdy) |=> !pred_bit && !pred_exh);
endmodule

bind bstr_stage bstr_stage_chk #(.M(M), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .ld_vld(ld_vld), .ld_rdy(ld_rdy), .br_vld(br_vld),
  .pkt_end(pkt_end), .pred_bit(pred_bit), .pred_exh(pred_exh), .wb_req(wb_req),
  .wb_data(wb_data), .wb_idx(wb_idx), .wb_ack(wb_ack)
);

// File: tb/sim_bstr_stage.sv
module sim_bstr_stage;
  localparam int M  = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_vld = 1'b0, ld_hit = 1'b0;
  logic [M-1:0]  ld_data = '0;
  logic [IW-1:0] ld_idx = '0;
  logic          ld_rdy;
  logic          br_vld = 1'b0, br_taken = 1'b0, pkt_end = 1'b0, wb_ack = 1'b0;
  logic          pred_bit, pred_exh, wb_req;
  logic [M-1:0]  wb_data;
  logic [IW-1:0] wb_idx;

  int n_vec = 0;
  int n_bad = 0;
  int wd    = 0;

  always #2 clk = ~clk;

  bstr_stage #(.M(M), .IW(IW)) u0 (
    .clk(clk), .rst(rst), .ld_vld(ld_vld), .ld_hit(ld_hit), .ld_data(ld_data),
    .ld_idx(ld_idx), .ld_rdy(ld_rdy), .br_vld(br_vld), .br_taken(br_taken),
    .pkt_end(pkt_end), .pred_bit(pred_bit), .pred_exh(pred_exh), .wb_req(wb_req),
    .wb_data(wb_data), .wb_idx(wb_idx), .wb_ack(wb_ack)
  );

  typedef struct {
    logic          p;
    logic          e;
    logic          r;
    logic [M-1:0]  d;
    logic [IW-1:0] ix;
    string         tag;
  } exp_t;

  exp_t q[$];
  exp_t x;

  task automatic drive(input logic l, input logic h, input logic [M-1:0] d,
                       input logic [IW-1:0] i, input logic b, input logic t,
                       input logic pe, input logic a);
    @(negedge clk);
    ld_vld = l; ld_hit = h; ld_data = d; ld_idx = i;
    br_vld = b; br_taken = t; pkt_end = pe; wb_ack = a;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic expect_out(input logic p, input logic e, input logic r,
                            input logic [M-1:0] d, input logic [IW-1:0] ix,
                            input string tag);
    exp_t it;
    it.p = p; it.e = e; it.r = r; it.d = d; it.ix = ix; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare the state that follows each driven edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      x = q.pop_front();
      n_vec++;
      if (pred_bit !== x.p || pred_exh !== x.e || wb_req !== x.r || ld_rdy !== !x.r ||
          (x.r && (wb_data !== x.d || wb_idx !== x.ix))) begin
        n_bad++;
        $display("FAIL %s: got p=%b e=%b r=%b rdy=%b d=%h ix=%0d exp p=%b e=%b r=%b rdy=%b d=%h ix=%0d",
                 x.tag, pred_bit, pred_exh, wb_req, ld_rdy, wb_data, wb_idx,
                 x.p, x.e, x.r, !x.r, x.d, x.ix);
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 5000) begin
      n_bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  localparam logic [M-1:0] STR_A = 16'hA5C3;
  localparam logic [M-1:0] STR_B = 16'h3C96;
  localparam logic [M-1:0] STR_C = 16'h5A5D;
  localparam logic [M-1:0] STR_D = 16'h0F0E;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    idle(); expect_out(1'b0, 1'b0, 1'b0, '0, '0, "R1 reset");

    // R2/R3/R4: hit replay
    drive(1'b1, 1'b1, STR_A, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out(STR_A[0], 1'b0, 1'b0, '0, '0, "R2 load");
    for (int k = 1; k <= M; k++) begin
      drive(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
      if (k < M) expect_out(STR_A[k], 1'b0, 1'b0, '0, '0, "R3 step");
      else       expect_out(1'b0, 1'b1, 1'b0, '0, '0, "R4 exhausted");
    end
    drive(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_out(1'b0, 1'b1, 1'b0, '0, '0, "R4 extra consume");
    drive(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out(1'b0, 1'b0, 1'b0, '0, '0, "R11 end idle");

    // R5/R6: miss, record a full string
    drive(1'b1, 1'b0, 16'hFFFF, 4'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out(1'b0, 1'b0, 1'b0, '0, '0, "R5 miss load");
    for (int k = 0; k < M; k++) begin
      drive(1'b0, 1'b0, '0, '0, 1'b1, STR_B[k], 1'b0, 1'b0);
      if (k < M - 1) expect_out(1'b0, 1'b0, 1'b0, '0, '0, "R5 record");
      else           expect_out(1'b0, 1'b1, 1'b1, STR_B, 4'd5, "R6 full write");
    end
    drive(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out(1'b0, 1'b0, 1'b1, STR_B, 4'd5, "R6 single write");
    idle(); expect_out(1'b0, 1'b0, 1'b1, STR_B, 4'd5, "R9 hold");
    drive(1'b1, 1'b1, 16'hFFFF, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out(1'b0, 1'b0, 1'b1, STR_B, 4'd5, "R10 stalled load");
    drive(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_out(1'b0, 1'b0, 1'b0, '0, '0, "R9 drop");

    // R7: partial write at packet end
    drive(1'b1, 1'b0, '0, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out(1'b0, 1'b0, 1'b0, '0, '0, "R5 miss load 2");
    for (int k = 0; k < 5; k++) begin
      drive(1'b0, 1'b0, '0, '0, 1'b1, STR_C[k], 1'b0, 1'b0);
      expect_out(1'b0, 1'b0, 1'b0, '0, '0, "R5 record 2");
    end
    drive(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out(1'b0, 1'b0, 1'b1, 16'h001D, 4'd9, "R7 partial write");
    drive(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_out(1'b0, 1'b0, 1'b0, '0, '0, "R9 drop 2");

    // R8: empty miss packet
    drive(1'b1, 1'b0, '0, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out(1'b0, 1'b0, 1'b0, '0, '0, "R5 miss load 3");
    drive(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out(1'b0, 1'b0, 1'b0, '0, '0, "R8 empty end");

    // R8: hit packet ending early
    drive(1'b1, 1'b1, STR_D, 4'd7, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out(STR_D[0], 1'b0, 1'b0, '0, '0, "R2 load 2");
    for (int k = 1; k <= 3; k++) begin
      drive(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
      expect_out(STR_D[k], 1'b0, 1'b0, '0, '0, "R3 step 2");
    end
    drive(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out(1'b0, 1'b0, 1'b0, '0, '0, "R8 hit end");
    idle(); expect_out(1'b0, 1'b0, 1'b0, '0, '0, "R11 idle");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule